// File: doc/BRIEF.md
# Store-and-Forward Packet FIFO

This block is a single-clock packet buffer for 64-bit packet streams. It sits in front of a consumer that cannot tolerate a packet arriving in pieces. Beats are written through a valid/ready interface that marks the first and last beat of each packet. A packet is offered at the output only after its last beat is in the buffer. From then on, the packet leaves as one unbroken run of beats, and it pauses only when the consumer lowers ready.

Release is governed by a count of complete packets held in the buffer. The count rises when a last beat is written and falls when a last beat is read. The output is valid exactly while that count is non-zero. Because the count only falls at a packet's last beat, the output stays valid from the first beat of a packet to its last. The buffer depth is a parameter and must be at least the length of the longest packet, in beats. Full and empty flags report the buffer's beat occupancy. The output reads the storage directly, so consecutive beats and consecutive packets leave on consecutive cycles.

Top module: `pkt_sf_fifo`

## Requirements
- R1: While reset is applied and after its release, the buffer holds no beats: out_valid is 0, buf_empty is 1, buf_full is 0 and in_ready is 1.
- R2: No beat of a packet is offered (out_valid stays 0 for it) while its end-of-packet beat has not yet been accepted, however long the writer pauses.
- R3: In the cycle after a packet's end-of-packet beat is accepted, out_valid is 1 and the packet's first beat is presented.
- R4: Once a packet's first beat has been taken, out_valid is 1 in every cycle until its end-of-packet beat has been taken.
- R5: Beats leave in the order they were accepted, with their 64 data bits, start flag (out_sop) and end flag (out_eop) unchanged.
- R6: When DEPTH beats are stored, in_ready is 0 and buf_full is 1; in_ready returns to 1 in the cycle after one beat is read.
- R7: A beat offered with in_valid high while in_ready is 0 is not stored and never appears at the output.
- R8: Writing one packet's end beat while another packet's end beat is read in the same cycle keeps the count of complete packets unchanged, so the written packet is still offered.
- R9: With out_ready held at 1, the first beat of the next complete packet is presented in the cycle right after the previous packet's end beat is taken.
- R10: buf_empty is 1 exactly when no beats are stored.
- R11: While out_valid is 1 and out_ready is 0, out_valid stays 1 and the presented data and flags do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Writer offers a beat |
| in_ready | output | 1 | Buffer can accept a beat |
| in_data | input | DATA_W | Beat payload |
| in_sop | input | 1 | Offered beat is the first of a packet |
| in_eop | input | 1 | Offered beat is the last of a packet |
| out_valid | output | 1 | A beat of a complete packet is presented |
| out_ready | input | 1 | Consumer takes the presented beat |
| out_data | output | DATA_W | Presented payload |
| out_sop | output | 1 | Presented beat is the first of a packet |
| out_eop | output | 1 | Presented beat is the last of a packet |
| buf_full | output | 1 | DEPTH beats stored |
| buf_empty | output | 1 | No beats stored |

## Verification
The bench goes after the cases where a plain FIFO and a store-and-forward FIFO part ways. One is a partial packet left waiting for many cycles, which a design that forwarded early would start sending. Another is a packet's last beat being written in the same cycle that another packet's last beat is read; a counter that let either update win would strand the new packet or release a phantom one. The bench also fills the buffer with a single packet of exactly DEPTH beats and offers one more beat. A wrong full flag would either overwrite the oldest beat or deadlock with a packet that could never finish. Finally it stalls the consumer in the middle of a packet and runs back-to-back and single-beat packets, which expose lost bubbles, reordered beats or a valid that drops between packets.

// File: rtl/pkt_sf_fifo_pkg.sv
package pkt_sf_fifo_pkg;

  // Packet boundary marks stored next to each payload word.
  typedef struct packed {
    logic sop;
    logic eop;
  } sff_marks_t;

  localparam int unsigned SFF_MARK_W = $bits(sff_marks_t);

  // Width of a counter that must reach the value lim inclusive.
  function automatic int unsigned sff_cnt_w(input int unsigned lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

  // Width of an index into lim entries.
  function automatic int unsigned sff_idx_w(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim);
  endfunction

endpackage

// File: rtl/sff_rst_sync.sv
module sff_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  // Asserts at once with rst_n, deasserts two edges after rst_n rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/sff_store.sv
module sff_store #(
  parameter int unsigned WIDTH = 66,
  parameter int unsigned DEPTH = 16
) (
  input  logic                                      clk,
  input  logic                                      wr_en,
  input  logic [pkt_sf_fifo_pkg::sff_idx_w(DEPTH)-1:0] wr_addr,
  input  logic [WIDTH-1:0]                          wr_word,
  input  logic [pkt_sf_fifo_pkg::sff_idx_w(DEPTH)-1:0] rd_addr,
  output logic [WIDTH-1:0]                          rd_word
);

  localparam int unsigned AW     = pkt_sf_fifo_pkg::sff_idx_w(DEPTH);
  localparam int unsigned FLAT_W = DEPTH * WIDTH;

  logic [FLAT_W-1:0] flat;

  // One register per entry with its own decoded write enable.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    logic             sel;
    logic [WIDTH-1:0] entry_q;

    assign sel = wr_en && (wr_addr == AW'(gi));

    always_ff @(posedge clk) begin
      if (sel) begin
        entry_q <= wr_word;
      end
    end

    assign flat[gi*WIDTH +: WIDTH] = entry_q;
  end

  // Combinational read: the head entry is presented without a bubble.
  assign rd_word = flat[rd_addr*WIDTH +: WIDTH];

endmodule

// File: rtl/sff_ptr_ctl.sv
module sff_ptr_ctl #(
  parameter int unsigned DEPTH = 16
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          push,
  input  logic                                          pop,
  output logic [pkt_sf_fifo_pkg::sff_idx_w(DEPTH)-1:0]  wr_ptr,
  output logic [pkt_sf_fifo_pkg::sff_idx_w(DEPTH)-1:0]  rd_ptr,
  output logic                                          full,
  output logic                                          empty
);

  localparam int unsigned AW = pkt_sf_fifo_pkg::sff_idx_w(DEPTH);
  localparam int unsigned CW = pkt_sf_fifo_pkg::sff_cnt_w(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [AW-1:0] wr_q, wr_d;
  logic [AW-1:0] rd_q, rd_d;
  logic [CW-1:0] occ_q, occ_d;
  logic          occ_en;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_d   = push ? step(wr_q) : wr_q;
    rd_d   = pop  ? step(rd_q) : rd_q;
    occ_en = push ^ pop;
    occ_d  = occ_q;
    if (push && !pop) begin
      occ_d = occ_q + CW'(1);
    end else if (pop && !push) begin
      occ_d = occ_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
    end else if (push) begin
      wr_q <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (pop) begin
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
    end else if (occ_en) begin
      occ_q <= occ_d;
    end
  end

  assign wr_ptr = wr_q;
  assign rd_ptr = rd_q;
  assign full   = (occ_q == FULL_CNT);
  assign empty  = (occ_q == '0);

endmodule

// File: rtl/sff_pkt_count.sv
module sff_pkt_count #(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done_in,
  input  logic done_out,
  output logic have_pkt
);

  localparam int unsigned CW = pkt_sf_fifo_pkg::sff_cnt_w(DEPTH);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // A packet finishing on both sides in one cycle leaves the count as is.
  always_comb begin
    cnt_en = done_in ^ done_out;
    cnt_d  = cnt_q;
    if (done_in && !done_out) begin
      cnt_d = cnt_q + CW'(1);
    end else if (done_out && !done_in) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign have_pkt = (cnt_q != '0);

endmodule

// File: rtl/pkt_sf_fifo.sv
module pkt_sf_fifo #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              buf_full,
  output logic              buf_empty
);

  import pkt_sf_fifo_pkg::*;

  localparam int unsigned AW = sff_idx_w(DEPTH);
  localparam int unsigned WW = DATA_W + SFF_MARK_W;

  logic          rst_sync_n;
  logic          push;
  logic          pop;
  logic          have_pkt;
  logic          full;
  logic          empty;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [WW-1:0] wr_word;
  logic [WW-1:0] rd_word;
  sff_marks_t    wr_marks;
  sff_marks_t    rd_marks;

  sff_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign push = in_valid && !full;
  assign pop  = have_pkt && out_ready;

  assign wr_marks.sop = in_sop;
  assign wr_marks.eop = in_eop;
  assign wr_word      = {wr_marks, in_data};

  sff_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .push   (push),
    .pop    (pop),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .full   (full),
    .empty  (empty)
  );

  sff_store #(.WIDTH(WW), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (push),
    .wr_addr (wr_ptr),
    .wr_word (wr_word),
    .rd_addr (rd_ptr),
    .rd_word (rd_word)
  );

  assign rd_marks = rd_word[WW-1 -: SFF_MARK_W];

  sff_pkt_count #(.DEPTH(DEPTH)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .done_in  (push && in_eop),
    .done_out (pop && rd_marks.eop),
    .have_pkt (have_pkt)
  );

  assign in_ready  = !full;
  assign out_valid = have_pkt;
  assign out_data  = rd_word[DATA_W-1:0];
  assign out_sop   = rd_marks.sop;
  assign out_eop   = rd_marks.eop;
  assign buf_full  = full;
  assign buf_empty = empty;

endmodule

// File: rtl/pkt_sf_fifo_checker.sv
module pkt_sf_fifo_checker #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned DEPTH  = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_eop,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_sop,
  input logic              out_eop,
  input logic              buf_full,
  input logic              buf_empty
);

  logic [15:0] beats_q;
  logic [15:0] pkts_q;
  logic        acc;
  logic        take;

  assign acc  = in_valid && in_ready;
  assign take = out_valid && out_ready;

  // Shadow tallies built only from handshakes at the ports.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      beats_q <= '0;
      pkts_q  <= '0;
    end else begin
      beats_q <= beats_q + 16'(acc) - 16'(take);
      pkts_q  <= pkts_q + 16'(acc && in_eop) - 16'(take && out_eop);
    end
  end

  always @(posedge clk) begin
    if (!rst_sync_n) begin
      AST_RESET_IDLE: assert (!out_valid && buf_empty && in_ready); // R1
    end
  end

  AST_HOLD_BACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (pkts_q != 16'd0)); // R2

  AST_PRESENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pkts_q != 16'd0) |-> out_valid); // R3 R8

  AST_GAP_FREE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_ready && !out_eop) |=> out_valid); // R4

  AST_NEXT_SOP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && out_ready && out_eop) |=> (!out_valid || out_sop)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (beats_q <= 16'(DEPTH)) && (buf_full == (beats_q == 16'(DEPTH)))); // R6

  AST_EMPTY_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    buf_empty == (beats_q == 16'd0)); // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop))); // R11

endmodule

bind pkt_sf_fifo pkt_sf_fifo_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_checker (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_eop     (in_eop),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_sop    (out_sop),
  .out_eop    (out_eop),
  .buf_full   (buf_full),
  .buf_empty  (buf_empty)
);

// File: tb/pkt_sf_fifo_bench.sv
module pkt_sf_fifo_bench;

  localparam int DATA_W = 64;
  localparam int DEPTH  = 8;

  logic              clk;
  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [DATA_W-1:0] in_data;
  logic              in_sop;
  logic              in_eop;
  logic              out_valid;
  logic              out_ready;
  logic [DATA_W-1:0] out_data;
  logic              out_sop;
  logic              out_eop;
  logic              buf_full;
  logic              buf_empty;

  int checks;
  int errors;

  pkt_sf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_pkt_sf_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .buf_full  (buf_full),
    .buf_empty (buf_empty)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // One row per cycle: inputs driven, then the outputs expected before that edge.
  typedef struct packed {
    logic       iv;
    logic       isop;
    logic       ieop;
    logic [7:0] itag;
    logic       ordy;
    logic       ev;
    logic       esop;
    logic       eeop;
    logic [7:0] etag;
    logic       erdy;
    logic       eempty;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1, 1'b1, 1'b0, 8'h11, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1}, // c0
    '{1'b1, 1'b0, 1'b0, 8'h12, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0}, // R2 partial
    '{1'b1, 1'b0, 1'b1, 8'h13, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0}, // R2 partial
    '{1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h11, 1'b1, 1'b0}, // R3 released
    '{1'b1, 1'b1, 1'b0, 8'h21, 1'b1, 1'b1, 1'b0, 1'b0, 8'h12, 1'b1, 1'b0}, // R4
    '{1'b1, 1'b0, 1'b1, 8'h22, 1'b1, 1'b1, 1'b0, 1'b1, 8'h13, 1'b1, 1'b0}, // R8 eop both ways
    '{1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h21, 1'b1, 1'b0}, // R9 no bubble
    '{1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h22, 1'b1, 1'b0}, // R5
    '{1'b1, 1'b1, 1'b0, 8'h31, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1}, // R10 empty
    '{1'b1, 1'b0, 1'b1, 8'h32, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h31, 1'b1, 1'b0}, // R11 stall
    '{1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h31, 1'b1, 1'b0}, // R11 stall
    '{1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h31, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h32, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1},
    '{1'b1, 1'b1, 1'b1, 8'h41, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1}, // single beat
    '{1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h41, 1'b1, 1'b0}, // R3 R5
    '{1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic iv, input logic sop, input logic eop,
                       input logic [7:0] tag, input logic ordy);
    in_valid  = iv;
    in_sop    = sop;
    in_eop    = eop;
    in_data   = {8{tag}};
    out_ready = ordy;
  endtask

  task automatic chk_beat(input string req, input logic sop, input logic eop,
                          input logic [7:0] tag);
    chk(req, "out_valid", 64'(out_valid), 64'd1);
    chk(req, "out_sop",   64'(out_sop),   64'(sop));
    chk(req, "out_eop",   64'(out_eop),   64'(eop));
    chk(req, "out_data",  out_data,       {8{tag}});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk("R1", "out_valid", 64'(out_valid), 64'd0);
    chk("R1", "buf_empty", 64'(buf_empty), 64'd1);
    chk("R1", "buf_full",  64'(buf_full),  64'd0);
    chk("R1", "in_ready",  64'(in_ready),  64'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "out_valid after release", 64'(out_valid), 64'd0);
    chk("R1", "buf_empty after release", 64'(buf_empty), 64'd1);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      chk("R6", "in_ready", 64'(in_ready), 64'(VEC[k].erdy));
      chk("R10", "buf_empty", 64'(buf_empty), 64'(VEC[k].eempty));
      chk("R3", "out_valid", 64'(out_valid), 64'(VEC[k].ev));
      if (VEC[k].ev) begin
        chk_beat("R5", VEC[k].esop, VEC[k].eeop, VEC[k].etag);
      end
      drive(VEC[k].iv, VEC[k].isop, VEC[k].ieop, VEC[k].itag, VEC[k].ordy);
      @(negedge clk);
    end
    drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    @(negedge clk);

    // R2: a partial packet is held back across a long writer pause
    drive(1'b1, 1'b1, 1'b0, 8'h51, 1'b1);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    for (int k = 0; k < 20; k++) begin
      chk("R2", "out_valid during pause", 64'(out_valid), 64'd0);
      @(negedge clk);
    end
    drive(1'b1, 1'b0, 1'b1, 8'h52, 1'b1);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    chk_beat("R3", 1'b1, 1'b0, 8'h51);
    @(negedge clk);
    chk_beat("R4", 1'b0, 1'b1, 8'h52);
    @(negedge clk);
    chk("R10", "buf_empty", 64'(buf_empty), 64'd1);

    // R6/R7: one packet of exactly DEPTH beats, then a refused extra beat
    for (int k = 0; k < DEPTH; k++) begin
      chk("R6", "in_ready while filling", 64'(in_ready), 64'd1);
      drive(1'b1, k == 0, k == DEPTH - 1, 8'(8'h60 + k), 1'b0);
      @(negedge clk);
    end
    drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    chk("R6", "in_ready at full", 64'(in_ready), 64'd0);
    chk("R6", "buf_full at full", 64'(buf_full), 64'd1);
    chk("R3", "out_valid full packet", 64'(out_valid), 64'd1);
    drive(1'b1, 1'b1, 1'b1, 8'hEE, 1'b0);
    repeat (2) @(negedge clk);
    chk("R7", "in_ready still low", 64'(in_ready), 64'd0);
    drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    for (int k = 0; k < DEPTH; k++) begin
      chk_beat("R4", k == 0, k == DEPTH - 1, 8'(8'h60 + k));
      @(negedge clk);
      if (k == 0) begin
        chk("R6", "in_ready after one read", 64'(in_ready), 64'd1);
      end
    end
    chk("R7", "refused beat absent", 64'(out_valid), 64'd0);
    chk("R7", "buffer drained", 64'(buf_empty), 64'd1);

    // R1: reset in the middle of operation discards stored beats
    drive(1'b1, 1'b1, 1'b0, 8'h71, 1'b0);
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b1, 8'h72, 1'b0);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    chk("R3", "out_valid before reset", 64'(out_valid), 64'd1);
    rst_n = 1'b0;
    #1;
    chk("R1", "out_valid in reset", 64'(out_valid), 64'd0);
    chk("R1", "buf_empty in reset", 64'(buf_empty), 64'd1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "out_valid after reset", 64'(out_valid), 64'd0);
    chk("R1", "in_ready after reset",  64'(in_ready),  64'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule